// File: doc/BRIEF.md
# Serial Character Time Generator

This block works out how long one asynchronous serial character lasts and counts that time out in system clocks. The frame settings arrive as an 8-bit mode byte: data length, parity enable, stop-bit count and a 2-bit clock-select field. A separate bit-rate byte goes with them. Whenever either byte is written, the block stores a new character period. The character's bit count is multiplied by a per-bit time of 32 × rate × 4^select clocks.

The transmit side restarts its timer on every transmit start. When the timer runs out, `tx_done` pulses to close the byte. The receive side gates incoming bytes. After a byte is accepted, `rx_ready` stays low for one character period, so the next byte cannot land too early. Receive starts count only while the receiver is enabled and ready. Line sampling and bit shifting belong to the surrounding serial port.

Top module: `char_time_gen`

## Requirements
- R1: Bits per character = 8, minus 1 when mode bit 6 (short data) is set, plus 1 when mode bit 5 (parity) is set, plus 2 stop bits when mode bit 3 is set or 1 stop bit otherwise.
- R2: Mode bits 1:0 select a clock divider of 1, 4, 16 or 64 for the values 0, 1, 2 and 3. The per-bit time is 32 × rate × divider clocks.
- R3: A character period T is the bit count times the per-bit time. `tx_done` is high in the cycle after the T-th rising edge that follows the edge sampling `tx_start`, and it is low before that.
- R4: `tx_done` lasts exactly one clock cycle.
- R5: A `tx_start` while a character is being timed restarts the count. No `tx_done` comes from the abandoned character, and the next one comes T edges after the latest start.
- R6: A rate value of 0 gives the same period as a rate value of 1.
- R7: `rx_ready` is low whenever `rx_en` is low. It is high when `rx_en` is high and no receive period is running.
- R8: A `rx_start` sampled while `rx_ready` is high drops `rx_ready` from the next cycle. `rx_ready` rises again after T edges.
- R9: A `rx_start` sampled while `rx_ready` is low has no effect. It neither extends a running period nor starts one when `rx_en` is low.
- R10: After reset, `tx_done` is low, the mode byte is 0 and the rate is 255, which gives T = 73440.
- R11: New settings apply to starts sampled after the write edge. A start sampled on the same edge as a write uses the old period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Write strobe for the mode byte |
| mode_i | input | 8 | Mode byte: select [1:0], two-stop [3], parity [5], short data [6] |
| rate_wr | input | 1 | Write strobe for the rate byte |
| rate_i | input | RATE_W | Bit-rate value |
| rx_en | input | 1 | Receiver enable |
| tx_start | input | 1 | Start of a transmitted byte |
| rx_start | input | 1 | A received byte is offered |
| tx_done | output | 1 | One-cycle end-of-character strobe |
| rx_ready | output | 1 | Receiver may accept a byte |

## Verification
A wrong stored period or a wrong field decode moves the `tx_done` edge by whole bit times. Each frame shape and divider is therefore timed to the exact cycle, which exposes such an error one character after the start. A counter that is not reloaded on a second start shows up as an early `tx_done` inside the window, well before T. A receive gate that accepts starts while busy or disabled leaves `rx_ready` low past the expected edge, so the rise of `rx_ready` is sampled at exactly T and at a point right after re-enabling.

// File: rtl/ctg_pkg.sv
package ctg_pkg;
  localparam int MODE_W    = 8;
  localparam int CKS_W     = 2;
  localparam int STOP_BIT  = 3;
  localparam int PAR_BIT   = 5;
  localparam int SHORT_BIT = 6;
  localparam int MAX_BITS  = 11;

  typedef struct packed {
    logic             short_data;
    logic             parity;
    logic             two_stop;
    logic [CKS_W-1:0] cks;
  } frame_cfg_t;

  function automatic frame_cfg_t decode_mode(input logic [MODE_W-1:0] m);
    frame_cfg_t f;
    f.short_data = m[SHORT_BIT];
    f.parity     = m[PAR_BIT];
    f.two_stop   = m[STOP_BIT];
    f.cks        = m[CKS_W-1:0];
    return f;
  endfunction

  // data bits + optional parity + one or two stop bits
  function automatic int unsigned frame_bits(input frame_cfg_t f);
    int unsigned b;
    b = f.short_data ? 32'd7 : 32'd8;
    if (f.parity) b = b + 32'd1;
    b = b + (f.two_stop ? 32'd2 : 32'd1);
    return b;
  endfunction

  // clocks per bit; a zero rate behaves as one
  function automatic int unsigned bit_clocks(input frame_cfg_t f,
                                             input int unsigned rate,
                                             input int unsigned scale);
    int unsigned r;
    r = (rate == 32'd0) ? 32'd1 : rate;
    return (scale * r) << (32'd2 * 32'(f.cks));
  endfunction

  function automatic int unsigned char_clocks(input frame_cfg_t f,
                                              input int unsigned rate,
                                              input int unsigned scale);
    return frame_bits(f) * bit_clocks(f, rate, scale);
  endfunction
endpackage

// File: rtl/ctg_cfg.sv
module ctg_cfg #(
  parameter int RATE_W     = 8,
  parameter int BIT_SCALE  = 32,
  parameter int RESET_RATE = 255,
  parameter int CNT_W      = 23
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mode_wr,
  input  logic [ctg_pkg::MODE_W-1:0] mode_i,
  input  logic                      rate_wr,
  input  logic [RATE_W-1:0]         rate_i,
  output logic [CNT_W-1:0]          char_clks
);
  import ctg_pkg::*;

  frame_cfg_t        frame_q, frame_nxt;
  logic [RATE_W-1:0] rate_q, rate_nxt;

  always_comb begin
    frame_nxt = mode_wr ? decode_mode(mode_i) : frame_q;
    rate_nxt  = rate_wr ? rate_i : rate_q;
  end

  // the period is computed from the incoming byte so it is valid right after the write edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q   <= frame_cfg_t'('0);
      rate_q    <= RATE_W'(RESET_RATE);
      char_clks <= CNT_W'(char_clocks(frame_cfg_t'('0), 32'(RESET_RATE),
                                      32'(BIT_SCALE)));
    end else if (mode_wr || rate_wr) begin
      frame_q   <= frame_nxt;
      rate_q    <= rate_nxt;
      char_clks <= CNT_W'(char_clocks(frame_nxt, 32'(rate_nxt), 32'(BIT_SCALE)));
    end
  end
endmodule

// File: rtl/ctg_count.sv
module ctg_count #(
  parameter int CNT_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic last_tick;
  assign last_tick = (cnt == ONE) && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= last_tick;
      if (load)            cnt <= period;
      else if (cnt != '0)  cnt <= cnt - ONE;
    end
  end
endmodule

// File: rtl/char_time_gen.sv
module char_time_gen #(
  parameter int RATE_W     = 8,
  parameter int BIT_SCALE  = 32,
  parameter int RESET_RATE = 255,
  localparam int MAX_DIV   = 1 << (2 * ((1 << ctg_pkg::CKS_W) - 1)),
  localparam int MAX_CLKS  = ctg_pkg::MAX_BITS * BIT_SCALE * ((1 << RATE_W) - 1) * MAX_DIV,
  localparam int CNT_W     = $clog2(MAX_CLKS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mode_wr,
  input  logic [ctg_pkg::MODE_W-1:0] mode_i,
  input  logic                       rate_wr,
  input  logic [RATE_W-1:0]          rate_i,
  input  logic                       rx_en,
  input  logic                       tx_start,
  input  logic                       rx_start,
  output logic                       tx_done,
  output logic                       rx_ready
);
  logic [CNT_W-1:0] char_q;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic             tx_load, rx_load, rx_expire;

  ctg_cfg #(
    .RATE_W(RATE_W), .BIT_SCALE(BIT_SCALE), .RESET_RATE(RESET_RATE), .CNT_W(CNT_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .mode_wr(mode_wr), .mode_i(mode_i),
    .rate_wr(rate_wr), .rate_i(rate_i),
    .char_clks(char_q)
  );

  assign tx_load  = tx_start;
  assign rx_ready = rx_en && (rx_cnt == '0);
  assign rx_load  = rx_start && rx_ready;

  ctg_count #(.CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .period(char_q),
    .cnt(tx_cnt), .expire(tx_done)
  );

  ctg_count #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .load(rx_load), .period(char_q),
    .cnt(rx_cnt), .expire(rx_expire)
  );
endmodule

// File: rtl/ctg_chk.sv
module ctg_chk #(
  parameter int CNT_W = 23
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_en,
  input logic             rx_start,
  input logic             rx_ready,
  input logic             tx_start,
  input logic             tx_done,
  input logic             rx_load,
  input logic             rx_expire,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt,
  input logic [CNT_W-1:0] char_q
);
  // R3
  tx_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == CNT_W'(1) && !tx_start) |=> tx_done);

  // R4
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  // R5
  tx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_done);

  // R6
  char_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_q != '0);

  // R7
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !rx_ready);

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> !rx_ready);

  // R8
  rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_expire && rx_en) |-> rx_ready);

  // R9
  rx_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_start && !rx_ready && rx_cnt != '0) |=> rx_cnt == $past(rx_cnt) - CNT_W'(1));
endmodule

bind char_time_gen ctg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_start(rx_start),
  .rx_ready(rx_ready), .tx_start(tx_start), .tx_done(tx_done),
  .rx_load(rx_load), .rx_expire(rx_expire), .tx_cnt(tx_cnt),
  .rx_cnt(rx_cnt), .char_q(char_q)
);

// File: tb/sim_char_time_gen.sv
module sim_char_time_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_wr = 1'b0, rate_wr = 1'b0;
  logic [7:0] mode_i = '0, rate_i = '0;
  logic       rx_en = 1'b0, tx_start = 1'b0, rx_start = 1'b0;
  logic       tx_done, rx_ready;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  char_time_gen u0 (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_i(mode_i),
    .rate_wr(rate_wr), .rate_i(rate_i), .rx_en(rx_en),
    .tx_start(tx_start), .rx_start(rx_start),
    .tx_done(tx_done), .rx_ready(rx_ready)
  );

  function automatic int exp_clocks(input bit [7:0] m, input bit [7:0] r);
    int nbits, div, rr;
    nbits = 8 - int'(m[6]) + int'(m[5]) + 1 + int'(m[3]);
    div   = 1;
    for (int k = 0; k < int'(m[1:0]); k++) div = div * 4;
    rr    = (r == 8'd0) ? 1 : int'(r);
    return nbits * 32 * rr * div;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input bit [7:0] m, input bit [7:0] r);
    @(negedge clk);
    mode_wr = 1'b1; mode_i = m; rate_wr = 1'b1; rate_i = r;
    @(negedge clk);
    mode_wr = 1'b0; rate_wr = 1'b0;
  endtask

  // pulses tx_start and times the done strobe against t
  task automatic run_tx(input int t, input string req);
    bit early = 1'b0;
    @(negedge clk);
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    if (tx_done) early = 1'b1;
    for (int i = 1; i < t; i++) begin
      @(negedge clk);
      if (tx_done) early = 1'b1;
    end
    check(!early, req, int'(early), 0);
    @(negedge clk);
    check(tx_done, req, int'(tx_done), 1);
    @(negedge clk);
    check(!tx_done, {req, " R4"}, int'(tx_done), 0);
  endtask

  task automatic test_reset;
    check(!tx_done, "R10", int'(tx_done), 0);
    check(!rx_ready, "R7", int'(rx_ready), 0);
    @(negedge clk);
    rx_en = 1'b1;
    #1;
    check(rx_ready, "R7", int'(rx_ready), 1);
    run_tx(exp_clocks(8'h00, 8'd255), "R10");
  endtask

  task automatic test_frames;
    set_cfg(8'h00, 8'd1);  run_tx(exp_clocks(8'h00, 8'd1), "R3");
    set_cfg(8'h68, 8'd2);  run_tx(exp_clocks(8'h68, 8'd2), "R1");
    set_cfg(8'h40, 8'd1);  run_tx(exp_clocks(8'h40, 8'd1), "R1");
    set_cfg(8'h20, 8'd3);  run_tx(exp_clocks(8'h20, 8'd3), "R1");
  endtask

  task automatic test_divider;
    set_cfg(8'h01, 8'd1);  run_tx(exp_clocks(8'h01, 8'd1), "R2");
    set_cfg(8'h02, 8'd1);  run_tx(exp_clocks(8'h02, 8'd1), "R2");
    set_cfg(8'h03, 8'd1);  run_tx(exp_clocks(8'h03, 8'd1), "R2");
  endtask

  task automatic test_rate_zero;
    set_cfg(8'h00, 8'd0);  run_tx(288, "R6");
  endtask

  task automatic test_restart;
    bit early = 1'b0;
    set_cfg(8'h00, 8'd1);
    @(negedge clk);
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tx_done) early = 1'b1;
    end
    check(!early, "R5", int'(early), 0);
    run_tx(exp_clocks(8'h00, 8'd1), "R5");
  endtask

  task automatic test_same_cycle_write;
    bit early = 1'b0;
    int t_old;
    t_old = exp_clocks(8'h00, 8'd1);
    @(negedge clk);
    mode_wr = 1'b1; mode_i = 8'h01; tx_start = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0; tx_start = 1'b0;
    for (int i = 1; i < t_old; i++) begin
      @(negedge clk);
      if (tx_done) early = 1'b1;
    end
    check(!early, "R11", int'(early), 0);
    @(negedge clk);
    check(tx_done, "R11", int'(tx_done), 1);
    run_tx(exp_clocks(8'h01, 8'd1), "R11");
  endtask

  task automatic rx_window(input bit inject, input string req);
    int  t;
    bit  early = 1'b0;
    t = exp_clocks(8'h00, 8'd1);
    set_cfg(8'h00, 8'd1);
    rx_en = 1'b1;
    @(negedge clk);
    check(rx_ready, req, int'(rx_ready), 1);
    rx_start = 1'b1;
    @(negedge clk);
    rx_start = 1'b0;
    check(!rx_ready, "R8", int'(rx_ready), 0);
    for (int i = 1; i < t; i++) begin
      @(negedge clk);
      if (rx_ready) early = 1'b1;
      if (inject && i == 50) rx_start = 1'b1;
      if (inject && i == 51) rx_start = 1'b0;
    end
    check(!early, req, int'(early), 0);
    @(negedge clk);
    check(rx_ready, req, int'(rx_ready), 1);
  endtask

  task automatic test_rx_disabled;
    @(negedge clk);
    rx_en = 1'b0;
    rx_start = 1'b1;
    @(negedge clk);
    rx_start = 1'b0;
    check(!rx_ready, "R7", int'(rx_ready), 0);
    rx_en = 1'b1;
    #1;
    check(rx_ready, "R9", int'(rx_ready), 1);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset;
    test_frames;
    test_divider;
    test_rate_zero;
    test_restart;
    set_cfg(8'h00, 8'd1);
    test_same_cycle_write;
    rx_window(1'b0, "R8");
    rx_window(1'b1, "R9");
    test_rx_disabled;
    report;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    report;
  end
endmodule